// File: doc/BRIEF.md
# UART Receive FIFO Controller

This block buffers received characters for a serial receiver. Complete bytes come in from a deserializer one per write strobe. A host register interface drains them one per read strobe. Storage is a 16-entry ring with a read pointer, a write pointer and a full flag. The full flag separates a full ring from an empty one when the two pointers meet. From the resulting fill level the block drives a Data Ready status bit, a sticky overrun bit and two interrupt requests.

The receive-data interrupt follows a programmable trigger level. The character-timeout interrupt reports bytes that sit below the trigger for too long. The timeout window is four character times. One character time is the frame length in bits times the bit period in clock cycles. Every accepted byte and every read that leaves data behind restarts this window.

A FIFO-clear input empties the ring and drops all receive status in one cycle, without a full block reset.

Top module: `rxq_ctrl`

## Requirements
- R1: After `rst` or a cycle with `fifo_clr` high, `fill_level` is 0 and `data_ready`, `rx_irq`, `tmo_irq` and `overrun` are all 0 from the next cycle on.
- R2: Bytes leave in the order they were accepted. `rd_data` shows the oldest stored byte whenever the ring holds data, and shows 0 when it is empty.
- R3: Sixteen writes with no reads make `fill_level` report 16, and the full state holds until a read or a clear.
- R4: A write while 16 bytes are held is dropped and leaves stored bytes untouched. It sets `overrun`, which stays set until `rst` or `fifo_clr`.
- R5: A read strobe on an empty ring changes no pointer, and `fill_level` stays 0.
- R6: `rx_irq` rises when a write brings the fill level to at least the trigger level. `trig_sel` encodes the trigger level as 0→1, 1→4, 2→8, 3→14 bytes. The comparison uses the unwrapped count, so a count of 16 is still seen.
- R7: After a read, `rx_irq` drops if the fill level is below the trigger level. It stays high while the level is still at or above it.
- R8: After every accepted read or write, `data_ready` equals (fill level ≠ 0), whatever the trigger comparison gives.
- R9: An accepted write, or a read that leaves bytes in the ring, arms a timer of 4·`frame_bits`·`bit_period` cycles. If the timer is not re-armed, `tmo_irq` rises exactly that many cycles after the arming edge. A ring emptied by a read never raises it.
- R10: `tmo_irq` clears on the next accepted read.
- R11: `fill_level` equals (write pointer − read pointer) mod 16, or 16 when the full flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clr | input | 1 | One-cycle clear of ring and receive status |
| wr_en | input | 1 | Deserializer delivers a byte |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Host reads one byte |
| rd_data | output | 8 | Oldest stored byte, 0 when empty |
| trig_sel | input | 2 | Trigger level select (0→1, 1→4, 2→8, 3→14) |
| frame_bits | input | 4 | Character frame length in bits |
| bit_period | input | 16 | Clock cycles per bit |
| fill_level | output | 5 | Bytes held, 0 to 16 |
| data_ready | output | 1 | Line status: at least one byte held |
| rx_irq | output | 1 | Fill level reached trigger |
| tmo_irq | output | 1 | Character timeout with data held |
| overrun | output | 1 | Sticky: a byte was dropped while full |

## Verification
The assertions assume `frame_bits` and `bit_period` stay constant while the timer runs. They also assume `rst` and `fifo_clr` are only sampled at clock edges. The bench programs the timing inputs once, before the first byte, and changes `trig_sel` only while the ring is idle. All strobes are driven on the falling edge. A single cycle may carry both a read and a write. The bench uses that only at fill levels where the trigger result is unambiguous.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int RXQ_DEPTH = 16;
    localparam int RXQ_DW    = 8;

    typedef enum logic [1:0] {
        TRIG_1  = 2'd0,
        TRIG_4  = 2'd1,
        TRIG_8  = 2'd2,
        TRIG_14 = 2'd3
    } trig_e;

    // per-cycle operations that actually take effect
    typedef struct packed {
        logic wr;
        logic rd;
    } rxq_op_t;

    function automatic logic [4:0] trig_level(input trig_e sel);
        case (sel)
            TRIG_1:  trig_level = 5'd1;
            TRIG_4:  trig_level = 5'd4;
            TRIG_8:  trig_level = 5'd8;
            default: trig_level = 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = rxq_pkg::RXQ_DEPTH,
    parameter int DW    = rxq_pkg::RXQ_DW,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] fill,
    output rxq_pkg::rxq_op_t op
);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          full;
    logic          has_data;

    assign has_data = full || (wptr != rptr);
    assign op.wr    = wr_req && !full;
    assign op.rd    = rd_req && has_data;
    assign fill     = full ? FULLV : {1'b0, wptr - rptr};
    assign rd_data  = has_data ? mem[rptr] : '0;

    always_ff @(posedge clk) begin
        if (op.wr)
            mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
            full <= 1'b0;
        end else begin
            if (op.wr)
                wptr <= wptr + 1'b1;
            if (op.rd)
                rptr <= rptr + 1'b1;
            if (op.rd)
                full <= 1'b0;
            else if (op.wr)
                full <= ((wptr + 1'b1) == rptr);
        end
    end

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fill == FULLV && !rd_req && !clr) |=> (fill == FULLV));

    // R11
    fill_lim_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= FULLV);

    // R5
    empty_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !wr_req && fill == '0 && !clr) |=> (fill == '0));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int FB_W = 4,
    parameter int BP_W = 16,
    localparam int TW  = FB_W + BP_W + 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm,
    input  logic            stop,
    input  logic [FB_W-1:0] frame_bits,
    input  logic [BP_W-1:0] bit_period,
    output logic            expire
);
    logic [TW-1:0] prod, limit, cnt;
    logic          active;

    assign prod   = TW'(frame_bits) * TW'(bit_period);
    assign limit  = prod << 2;
    assign expire = active && (cnt == '0) && !arm && !stop;

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (arm) begin
            active <= 1'b1;
            cnt    <= (limit == '0) ? '0 : limit - 1'b1;
        end else if (active) begin
            if (cnt == '0)
                active <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    // R9
    expire_once_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = rxq_pkg::RXQ_DEPTH,
    parameter int DW    = rxq_pkg::RXQ_DW,
    parameter int FB_W  = 4,
    parameter int BP_W  = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fifo_clr,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_en,
    output logic [DW-1:0]   rd_data,
    input  logic [1:0]      trig_sel,
    input  logic [FB_W-1:0] frame_bits,
    input  logic [BP_W-1:0] bit_period,
    output logic [CW-1:0]   fill_level,
    output logic            data_ready,
    output logic            rx_irq,
    output logic            tmo_irq,
    output logic            overrun
);
    import rxq_pkg::*;

    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    rxq_op_t       op;
    logic [CW-1:0] fill_nx;
    logic [CW-1:0] tlev;
    logic          t_arm, t_stop, t_expire;

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr     (fifo_clr),
        .wr_req  (wr_en),
        .rd_req  (rd_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .fill    (fill_level),
        .op      (op)
    );

    // unwrapped count after this cycle's operations (reaches DEPTH)
    assign fill_nx = fill_level + CW'(op.wr) - CW'(op.rd);
    assign tlev    = CW'(trig_level(trig_e'(trig_sel)));

    assign t_arm  = op.wr || (op.rd && fill_nx != '0);
    assign t_stop = fifo_clr || (op.rd && fill_nx == '0);

    rxq_timer #(.FB_W(FB_W), .BP_W(BP_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .arm        (t_arm),
        .stop       (t_stop),
        .frame_bits (frame_bits),
        .bit_period (bit_period),
        .expire     (t_expire)
    );

    always_ff @(posedge clk) begin
        if (rst || fifo_clr) begin
            rx_irq     <= 1'b0;
            data_ready <= 1'b0;
            tmo_irq    <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            if (op.wr && fill_nx >= tlev)
                rx_irq <= 1'b1;
            else if (op.rd && fill_nx < tlev)
                rx_irq <= 1'b0;

            if (op.wr || op.rd)
                data_ready <= (fill_nx != '0);

            if (op.rd)
                tmo_irq <= 1'b0;
            else if (t_expire)
                tmo_irq <= 1'b1;

            if (wr_en && !op.wr)
                overrun <= 1'b1;
        end
    end

    // R8
    dr_match_chk: assert property (@(posedge clk) disable iff (rst)
        data_ready == (fill_level != '0));

    // R1
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (fill_level == '0 && !data_ready && !rx_irq && !tmo_irq && !overrun));

    // R4
    ovr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fill_level == FULLV && !fifo_clr) |=> overrun);

    // R10
    tmo_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && fill_level != '0) |=> !tmo_irq);

endmodule

// File: tb/rxq_ctrl_test.sv
module rxq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst, fifo_clr, wr_en, rd_en;
    logic [7:0]  wr_data, rd_data;
    logic [1:0]  trig_sel;
    logic [3:0]  frame_bits;
    logic [15:0] bit_period;
    logic [4:0]  fill_level;
    logic        data_ready, rx_irq, tmo_irq, overrun;

    int errors = 0;
    int checks = 0;

    localparam int LIM = 4 * 10 * 3;

    always #10 clk = ~clk;

    rxq_ctrl uut (
        .clk(clk), .rst(rst), .fifo_clr(fifo_clr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .trig_sel(trig_sel), .frame_bits(frame_bits), .bit_period(bit_period),
        .fill_level(fill_level), .data_ready(data_ready), .rx_irq(rx_irq),
        .tmo_irq(tmo_irq), .overrun(overrun)
    );

    typedef struct packed {
        logic       w;
        logic       r;
        logic [7:0] wd;
        logic [7:0] rdat;
        logic [4:0] fill;
        logic       irq;
    } vec_t;

    // trigger level 4 throughout
    localparam vec_t TBL [16] = '{
        '{1'b1, 1'b0, 8'h11, 8'h00, 5'd1, 1'b0},
        '{1'b1, 1'b0, 8'h22, 8'h00, 5'd2, 1'b0},
        '{1'b1, 1'b0, 8'h33, 8'h00, 5'd3, 1'b0},
        '{1'b1, 1'b0, 8'h44, 8'h00, 5'd4, 1'b1},
        '{1'b0, 1'b1, 8'h00, 8'h11, 5'd3, 1'b0},
        '{1'b1, 1'b0, 8'h55, 8'h00, 5'd4, 1'b1},
        '{1'b0, 1'b1, 8'h00, 8'h22, 5'd3, 1'b0},
        '{1'b0, 1'b1, 8'h00, 8'h33, 5'd2, 1'b0},
        '{1'b0, 1'b1, 8'h00, 8'h44, 5'd1, 1'b0},
        '{1'b0, 1'b1, 8'h00, 8'h55, 5'd0, 1'b0},
        '{1'b0, 1'b1, 8'h00, 8'h00, 5'd0, 1'b0},
        '{1'b1, 1'b0, 8'h66, 8'h00, 5'd1, 1'b0},
        '{1'b1, 1'b0, 8'h77, 8'h00, 5'd2, 1'b0},
        '{1'b1, 1'b1, 8'h88, 8'h66, 5'd2, 1'b0},
        '{1'b0, 1'b1, 8'h00, 8'h77, 5'd1, 1'b0},
        '{1'b0, 1'b1, 8'h00, 8'h88, 5'd0, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_op(input logic w, input logic r, input logic [7:0] d);
        wr_en = w; rd_en = r; wr_data = d;
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic pulse_clr();
        fifo_clr = 1'b1;
        tick();
        fifo_clr = 1'b0;
    endtask

    task automatic check_idle(input string req);
        check(req, fill_level, 0);
        check(req, data_ready, 0);
        check(req, rx_irq, 0);
        check(req, tmo_irq, 0);
        check(req, overrun, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; fifo_clr = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        wr_data = '0; trig_sel = 2'd1; frame_bits = 4'd10; bit_period = 16'd3;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check_idle("R1 reset");
        check("R2 empty rd_data", rd_data, 0);

        // table walk: order, fill, trigger 4, data ready, empty read
        for (int i = 0; i < 16; i++) begin
            if (TBL[i].r)
                check("R2 order", rd_data, TBL[i].rdat);
            do_op(TBL[i].w, TBL[i].r, TBL[i].wd);
            check("R11 fill / R5 empty read", fill_level, TBL[i].fill);
            check("R6/R7 rx_irq", rx_irq, TBL[i].irq);
            check("R8 data_ready", data_ready, TBL[i].fill != 0);
        end

        // fill to 16 with trigger 14
        pulse_clr();
        trig_sel = 2'd3;
        for (int k = 0; k < 16; k++) begin
            do_op(1'b1, 1'b0, 8'hA0 + 8'(k));
            if (k == 12) check("R6 below 14", rx_irq, 0);
            if (k == 13) check("R6 at 14", rx_irq, 1);
        end
        check("R3 full count", fill_level, 16);
        check("R6 at 16", rx_irq, 1);
        do_op(1'b1, 1'b0, 8'hEE);
        check("R3 still full", fill_level, 16);
        check("R4 overrun set", overrun, 1);
        for (int k = 0; k < 16; k++) begin
            check("R4 data intact / R2 wrap order", rd_data, 8'hA0 + 8'(k));
            do_op(1'b0, 1'b1, 8'h00);
            if (k == 1) check("R7 stays at 14", rx_irq, 1);
            if (k == 2) check("R7 drops at 13", rx_irq, 0);
        end
        check("R8 empty after drain", data_ready, 0);
        check("R4 overrun sticky", overrun, 1);

        // clear on empty ring clears overrun
        pulse_clr();
        check_idle("R1 fifo_clr");

        // timeout from a single write
        do_op(1'b1, 1'b0, 8'h5A);
        repeat (LIM - 1) tick();
        check("R9 not yet", tmo_irq, 0);
        tick();
        check("R9 expiry", tmo_irq, 1);
        check("R6 below trigger", rx_irq, 0);
        do_op(1'b0, 1'b1, 8'h00);
        check("R10 cleared by read", tmo_irq, 0);
        repeat (LIM + 5) tick();
        check("R9 empty never fires", tmo_irq, 0);

        // re-arm by a read that leaves data
        do_op(1'b1, 1'b0, 8'h01);
        do_op(1'b1, 1'b0, 8'h02);
        repeat (50) tick();
        check("R9 early", tmo_irq, 0);
        do_op(1'b0, 1'b1, 8'h00);
        repeat (LIM - 1) tick();
        check("R9 re-armed not yet", tmo_irq, 0);
        tick();
        check("R9 re-armed expiry", tmo_irq, 1);
        check("R11 one left", fill_level, 1);

        // clear with data and timeout pending
        pulse_clr();
        check_idle("R1 clear busy");

        // trigger level 1
        trig_sel = 2'd0;
        do_op(1'b1, 1'b0, 8'h3C);
        check("R6 trigger 1", rx_irq, 1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check_idle("R1 reset busy");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule